// File: doc/BRIEF.md
# I2C Slave Interrupt Status Collector

This block gathers event indications from an I2C slave controller and keeps them as sticky pending flags in a nine-bit raw status word. Some sources are single-cycle pulses (START and STOP detection, the three data-path events, DMA completion). Others are FIFO conditions given as levels (receive full, transmit empty, receive and transmit trigger reached). Each level is turned into a one-cycle set pulse on its rising edge, so a condition that stays true does not raise its flag again once software has cleared it.

Software uses a small synchronous register port. It reads the raw flags, the enable mask and the masked flags, and it writes a separate clear word where each 1 clears the matching flag. A single interrupt line goes high while any flag that the mask enables is pending. The slave bus engine, the FIFOs and the DMA engine lie outside this block and only supply the input indications.

Top module: `slv_irq_status`

## Requirements
- R1: After reset the raw status, mask and masked status all read 0 and `irq` is 0.
- R2: Raw status bit order, from bit 8 down to 0: rx_full, tx_empty, rx_trig, tx_trig, dma_tx_done, dma_rx_done, STOP, START, data. Bits 31..9 of every read are 0, and the mask keeps only bits 8..0 of a write.
- R3: A one-cycle pulse on `start_det` sets bit 1 and a pulse on `stop_det` sets bit 2, seen on the first read issued after the pulse. Without a set event a bit never goes from 0 to 1.
- R4: A write to the clear offset clears every status bit where the written data has a 1. Bits written with 0 keep their value. A set bit keeps its value until it is cleared.
- R5: Bit 7 (tx_empty) is set only when `tx_empty` goes from 0 to 1. If bit 7 is cleared while `tx_empty` stays 1, it stays 0 until `tx_empty` falls and rises again.
- R6: Bit 0 (data) is set by a pulse on any of `rx_txn_done`, `tx_txn_req` or `next_byte_req`.
- R7: A pulse on `dma_tx_done` sets bit 4 and a pulse on `dma_rx_done` sets bit 3.
- R8: Bits 8, 6 and 5 are set on the rising edge of `rx_full`, `rx_trig` and `tx_trig`. If such a bit is cleared while its level stays high, it stays 0.
- R9: When a set event and a clear write of the same bit fall in the same cycle, the bit ends up set.
- R10: A read of the masked offset returns raw AND mask. `irq` is 1 exactly when that AND is nonzero.
- R11: Register word offsets (address bits 3:2) are 0 raw (read only), 1 mask (read/write), 2 masked (read only) and 3 clear (write only, reads 0). `reg_rdata` is updated on the clock edge where `reg_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | START condition seen (pulse) |
| stop_det | input | 1 | STOP condition seen (pulse) |
| rx_txn_done | input | 1 | Slave received a transaction (pulse) |
| tx_txn_req | input | 1 | Master requested a transaction from the slave (pulse) |
| next_byte_req | input | 1 | Next byte transfer requested (pulse) |
| dma_tx_done | input | 1 | Transmit DMA transfer complete (pulse) |
| dma_rx_done | input | 1 | Receive DMA transfer complete (pulse) |
| rx_full | input | 1 | Receive FIFO full (level) |
| tx_empty | input | 1 | Transmit FIFO empty (level) |
| rx_trig | input | 1 | Receive FIFO at trigger level (level) |
| tx_trig | input | 1 | Transmit FIFO at trigger level (level) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
A flag stored wrongly shows up on the first raw read after the cycle that corrupted it. If the mask enables that flag, it also shows on `irq` in the same cycle. An edge detector holding a stale previous level is the hard case. It either sets tx_empty again right after a clear, which the next read shows, or it misses the fill-then-drain edge, which only a full fill-and-drain run exposes. For that reason the bench runs both sequences on the transmit-empty and receive-full sources.

// File: rtl/slvirq_pkg.sv
package slvirq_pkg;

    localparam int STAT_W = 9;

    // bit positions of the raw status word
    localparam int B_DATA    = 0;
    localparam int B_START   = 1;
    localparam int B_STOP    = 2;
    localparam int B_DMA_RX  = 3;
    localparam int B_DMA_TX  = 4;
    localparam int B_TX_TRIG = 5;
    localparam int B_RX_TRIG = 6;
    localparam int B_TX_EMPT = 7;
    localparam int B_RX_FULL = 8;

    // level-sourced flags, index order of the level vector
    localparam int NUM_LVL = 4;

    typedef struct packed {
        logic rx_full;
        logic tx_empty;
        logic rx_trig;
        logic tx_trig;
        logic dma_tx;
        logic dma_rx;
        logic stop;
        logic start;
        logic data;
    } stat_t;

    typedef enum logic [1:0] {
        SEL_RAW  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_MSKD = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;

    localparam int SEL_LSB = 2;

    function automatic reg_sel_e sel_of(input logic [1:0] word_idx);
        return reg_sel_e'(word_idx);
    endfunction

endpackage

// File: rtl/slvirq_evt_capture.sv
module slvirq_evt_capture
    import slvirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic                rx_txn_done,
    input  logic                tx_txn_req,
    input  logic                next_byte_req,
    input  logic                dma_tx_done,
    input  logic                dma_rx_done,
    input  logic [NUM_LVL-1:0]  lvl,      // {rx_full, tx_empty, rx_trig, tx_trig}
    output stat_t               set_ev
);

    logic [NUM_LVL-1:0] lvl_prev;
    logic [NUM_LVL-1:0] lvl_rise;

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_edge
        // loading the live level during reset keeps a level that is
        // already high at release from looking like a fresh edge
        always_ff @(posedge clk) begin
            lvl_prev[k] <= lvl[k];
        end
        assign lvl_rise[k] = lvl[k] & ~lvl_prev[k];

        // steady high level must never produce a set pulse (R5, R8)
        p_level_no_reset_r8: assert property (@(posedge clk) disable iff (rst)
            (lvl[k] && $past(lvl[k])) |-> !lvl_rise[k]);
    end

    always_comb begin
        set_ev          = '0;
        set_ev.data     = rx_txn_done | tx_txn_req | next_byte_req;
        set_ev.start    = start_det;
        set_ev.stop     = stop_det;
        set_ev.dma_rx   = dma_rx_done;
        set_ev.dma_tx   = dma_tx_done;
        set_ev.tx_trig  = lvl_rise[0];
        set_ev.rx_trig  = lvl_rise[1];
        set_ev.tx_empty = lvl_rise[2];
        set_ev.rx_full  = lvl_rise[3];
    end

    p_txe_edge_only_r5: assert property (@(posedge clk) disable iff (rst)
        set_ev.tx_empty |-> (lvl[2] && !$past(lvl[2])));

endmodule

// File: rtl/slvirq_status_bits.sv
module slvirq_status_bits #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] stat
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat[i] <= 1'b0;
            end else begin
                // a set in the same cycle as a clear keeps the flag
                stat[i] <= set_v[i] | (stat[i] & ~clr_v[i]);
            end
        end

        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set_v[i] |=> stat[i]);

        p_clear_r4: assert property (@(posedge clk) disable iff (rst)
            (clr_v[i] && !set_v[i]) |=> !stat[i]);

        p_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (stat[i] && !clr_v[i]) |=> stat[i]);

        p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
            (!stat[i] && !set_v[i]) |=> !stat[i]);
    end

endmodule

// File: rtl/slvirq_reg_port.sv
module slvirq_reg_port
    import slvirq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STAT_W-1:0] raw,
    output logic [STAT_W-1:0] clr_v,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int PAD_W = DATA_W - STAT_W;

    reg_sel_e          sel;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] masked;
    logic [STAT_W-1:0] rd_mux;

    assign sel    = sel_of(addr[SEL_LSB +: 2]);
    assign masked = raw & mask_q;
    assign clr_v  = (wr && sel == SEL_CLR) ? wdata[STAT_W-1:0] : '0;
    assign irq    = |masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr && sel == SEL_MASK) begin
            mask_q <= wdata[STAT_W-1:0];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_RAW:  rd_mux = raw;
            SEL_MASK: rd_mux = mask_q;
            SEL_MSKD: rd_mux = masked;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= {{PAD_W{1'b0}}, rd_mux};
        end
    end

    p_clr_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == SEL_CLR) |=> (rdata == '0));

    p_masked_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == SEL_MSKD) |=> (rdata[STAT_W-1:0] == $past(raw & mask_q)));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:STAT_W] == '0);

endmodule

// File: rtl/slv_irq_status.sv
module slv_irq_status
    import slvirq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              rx_txn_done,
    input  logic              tx_txn_req,
    input  logic              next_byte_req,
    input  logic              dma_tx_done,
    input  logic              dma_rx_done,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              rx_trig,
    input  logic              tx_trig,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    stat_t             set_ev;
    logic [STAT_W-1:0] clr_v;
    logic [STAT_W-1:0] raw;

    slvirq_evt_capture u_cap (
        .clk           (clk),
        .rst           (rst),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .rx_txn_done   (rx_txn_done),
        .tx_txn_req    (tx_txn_req),
        .next_byte_req (next_byte_req),
        .dma_tx_done   (dma_tx_done),
        .dma_rx_done   (dma_rx_done),
        .lvl           ({rx_full, tx_empty, rx_trig, tx_trig}),
        .set_ev        (set_ev)
    );

    slvirq_status_bits #(.W(STAT_W)) u_bits (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_ev),
        .clr_v (clr_v),
        .stat  (raw)
    );

    slvirq_reg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .rd    (reg_rd),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .raw   (raw),
        .clr_v (clr_v),
        .rdata (reg_rdata),
        .irq   (irq)
    );

endmodule

// File: tb/slv_irq_status_test.sv
`timescale 1ns/1ps
module slv_irq_status_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  pulses = '0;   // start, stop, rx_done, tx_req, next_byte, dma_tx, dma_rx
    logic [3:0]  lvls = '0;     // {rx_full, tx_empty, rx_trig, tx_trig}
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic        rd_q = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [3:0] A_RAW = 4'h0, A_MASK = 4'h4, A_MSKD = 4'h8, A_CLR = 4'hC;

    always #10 clk = ~clk;   // 50 MHz

    slv_irq_status uut (
        .clk(clk), .rst(rst),
        .start_det(pulses[0]), .stop_det(pulses[1]), .rx_txn_done(pulses[2]),
        .tx_txn_req(pulses[3]), .next_byte_req(pulses[4]),
        .dma_tx_done(pulses[5]), .dma_rx_done(pulses[6]),
        .rx_full(lvls[3]), .tx_empty(lvls[2]), .rx_trig(lvls[1]), .tx_trig(lvls[0]),
        .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares read data one cycle after each read strobe
    always @(posedge clk) rd_q <= rd;
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        rd = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        pulses[k] = 1'b1;
        @(negedge clk);
        pulses[k] = 1'b0;
    endtask

    task automatic set_lvl(input int k, input logic v);
        @(negedge clk);
        lvls[k] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd_exp(A_RAW,  32'h0, "R1 raw after reset");
        rd_exp(A_MASK, 32'h0, "R1 mask after reset");
        rd_exp(A_MSKD, 32'h0, "R1 masked after reset");

        pulse(0); rd_exp(A_RAW, 32'h002, "R3 start sets bit1");
        pulse(1); rd_exp(A_RAW, 32'h006, "R3 stop sets bit2");
        wr_reg(A_CLR, 32'h0);   rd_exp(A_RAW, 32'h006, "R4 zero clear no effect");
        wr_reg(A_CLR, 32'h002); rd_exp(A_RAW, 32'h004, "R4 clear single bit");
        rd_exp(A_CLR, 32'h0, "R11 clear offset reads zero");
        wr_reg(A_CLR, 32'h1FF); rd_exp(A_RAW, 32'h0, "R4 clear all");

        pulse(2); rd_exp(A_RAW, 32'h001, "R6 rx transaction sets data");
        wr_reg(A_CLR, 32'h001);
        pulse(3); rd_exp(A_RAW, 32'h001, "R6 tx request sets data");
        wr_reg(A_CLR, 32'h001);
        pulse(4); rd_exp(A_RAW, 32'h001, "R6 next byte sets data");
        wr_reg(A_CLR, 32'h001);

        pulse(5); rd_exp(A_RAW, 32'h010, "R7 dma tx done bit4");
        pulse(6); rd_exp(A_RAW, 32'h018, "R7 dma rx done bit3");
        wr_reg(A_CLR, 32'h018); rd_exp(A_RAW, 32'h0, "R7 dma bits cleared");

        // transmit empty: edge set, no re-set while held, re-set after fill/drain
        set_lvl(2, 1'b1); rd_exp(A_RAW, 32'h080, "R5 tx empty rise sets bit7");
        wr_reg(A_CLR, 32'h080); idle(5);
        rd_exp(A_RAW, 32'h0, "R5 no reassert while still empty");
        set_lvl(2, 1'b0); idle(2); rd_exp(A_RAW, 32'h0, "R5 fill does not set");
        set_lvl(2, 1'b1); rd_exp(A_RAW, 32'h080, "R5 reassert after fill then drain");
        wr_reg(A_CLR, 32'h080); set_lvl(2, 1'b0);

        set_lvl(3, 1'b1); rd_exp(A_RAW, 32'h100, "R8 rx full rise sets bit8");
        wr_reg(A_CLR, 32'h100); idle(4);
        rd_exp(A_RAW, 32'h0, "R8 rx full held high no reset");
        set_lvl(1, 1'b1); rd_exp(A_RAW, 32'h040, "R8 rx trigger bit6");
        set_lvl(0, 1'b1); rd_exp(A_RAW, 32'h060, "R8 tx trigger bit5");
        wr_reg(A_CLR, 32'h1FF);
        set_lvl(0, 1'b0); set_lvl(1, 1'b0); set_lvl(3, 1'b0);
        rd_exp(A_RAW, 32'h0, "R8 falling levels do not set");

        // set and clear in the same cycle
        @(negedge clk);
        pulses[0] = 1'b1; wr = 1'b1; addr = A_CLR; wdata = 32'h002;
        @(negedge clk);
        pulses[0] = 1'b0; wr = 1'b0;
        rd_exp(A_RAW, 32'h002, "R9 set wins over clear");
        wr_reg(A_CLR, 32'h1FF);

        // mask and masked readback
        wr_reg(A_MASK, 32'h006); rd_exp(A_MASK, 32'h006, "R11 mask readback");
        chk("R10 irq low with nothing pending", {31'b0, irq}, 32'h0);
        pulse(1); rd_exp(A_MSKD, 32'h004, "R10 masked status");
        chk("R10 irq high on enabled flag", {31'b0, irq}, 32'h1);
        wr_reg(A_MASK, 32'h001); rd_exp(A_MSKD, 32'h0, "R10 masked off");
        chk("R10 irq low when masked", {31'b0, irq}, 32'h0);
        wr_reg(A_RAW, 32'h0);  rd_exp(A_RAW, 32'h004, "R11 raw offset not writable");

        wr_reg(A_MASK, 32'hFFFF_FFFF); rd_exp(A_MASK, 32'h1FF, "R2 mask upper bits dropped");
        wr_reg(A_CLR, 32'h1FF);
        set_lvl(3, 1'b1); pulse(2);
        rd_exp(A_RAW, 32'h101, "R2 bit order rx_full and data");
        set_lvl(3, 1'b0);

        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule